// File: doc/BRIEF.md
# Exception Vector Address Generator

This block works out where a processor core jumps when it takes an exception or an interrupt, and how the Cause word changes at that moment. The core presents the kind of event together with the current Status, Cause, Config3 and exception-base words, the raw interrupt vector-spacing field and, for TLB refills, the faulting address region. One cycle later the block returns the handler entry address, the updated Cause word and the instruction-set mode flag for the handler's first instruction, together with a one-cycle valid strobe.

Interrupt entries can be vectored. The masked pending lines select a vector number. That number comes either from a priority scan inside the block or, with an external interrupt controller, straight from the pending lines. The vector is then scaled by a programmable spacing and placed above the interrupt area at offset 0x200. Boot-time events (reset, soft reset, NMI) and debug entries use fixed addresses in the boot region. All other entries add an offset to a base. That base is either the boot-region base or the exception-base register, aligned to 1 KiB.

Top module: `exc_vector_gen`

## Requirements
- R1: `out_valid` is high for exactly the cycle after each cycle with `req_valid` high. `new_pc`, `cause_out` and `isa16_mode` are loaded only on a request and otherwise keep their values, whatever the inputs do.
- R2: While `rst` is high at a clock edge, all outputs are cleared to zero on that edge.
- R3: Reset (kind 0), soft reset (kind 1) and NMI (kind 2) enter at 0xBFC00000. Debug (kind 3) enters at 0xBFC00480. None of these four changes the Cause code field.
- R4: For NMI and debug, Cause bit 31 (branch delay) is cleared when Status bit 1 (EXL) is 0 and kept when it is 1. No other kind touches bit 31.
- R5: For every other kind the base is 0xBFC00200 when Status bit 22 (BEV) is 1, and otherwise the exception base with bits 9:0 forced to zero. The entry is base plus offset modulo 2^32. The default offset is 0x180.
- R6: Cause bits 6:2 receive the event code: interrupt (kind 4) 0, thread (kind 7) 25, DSP disabled (kind 8) 26, cache error (kind 9) 30, TLB refill (kind 5) and other (kind 6) take `exc_code`. Every Cause bit outside 6:2 and 31 passes through unchanged.
- R7: An interrupt with both vectored modes off uses offset 0x200 when Cause bit 23 (IV) is 1, and 0x180 otherwise.
- R8: The masked pending set is Cause bits 15:8 ANDed with Status bits 15:8. The spacing is bits 5:0 of `intctl_spacing` times 32, so bits 7:6 have no effect.
- R9: With Config3 bit 5 set (internal vectoring), the vector is the highest set bit among masked pending bits 7 down to 1, or 0 if none of them is set. This mode wins over external vectoring. The offset is 0x200 plus vector times spacing.
- R10: With only Config3 bit 6 set (external vectoring), the vector is the whole 8-bit masked pending value, and the offset is 0x200 plus vector times spacing.
- R11: A TLB refill uses offset 0x080 when the region's extension enable is set, and offset 0x000 otherwise. The regions are `fault_region` 0 with Status bit 5, 1 with Status bit 6, and 3 with Status bit 7. Region 2 always uses 0x000.
- R12: With `HAS_CISA` = 1 the handler mode flag is Config3 bit 16. With `HAS_CISA` = 0 it is 0.
- R13: Kind codes 10 to 15 behave exactly like kind 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An exception is being taken this cycle |
| exc_kind | input | 4 | Event kind code (see R3, R6, R13) |
| fault_region | input | 2 | Address region of a TLB refill: 0 user, 1 supervisor, 3 kernel |
| exc_code | input | 5 | Cause code for TLB refill and other kinds |
| status_in | input | 32 | Current Status word |
| cause_in | input | 32 | Current Cause word |
| config3_in | input | 32 | Current Config3 word |
| intctl_spacing | input | 8 | Raw vector spacing field |
| ebase_in | input | 32 | Exception base register |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| new_pc | output | 32 | Handler entry address |
| cause_out | output | 32 | Updated Cause word |
| isa16_mode | output | 1 | Compressed-ISA mode flag on handler entry |

## Verification
The assertions assume that `req_valid` and `exc_kind` are never unknown after reset, and that the inputs on a request cycle are the ones the result must reflect. Their `$past` terms read the inputs of the request cycle only, so the bench holds every input steady from one falling edge to the next. It pulses requests singly or back to back, and changes the inputs freely in idle cycles, because nothing is loaded then. The checks on fixed entry addresses assume that kinds 0 to 3 never depend on Config3 or on the exception base, and the stimulus gives those kinds arbitrary values there.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    localparam int VA_W       = 32;
    localparam int IRQ_W      = 8;
    localparam int SPC_RAW_W  = 8;
    localparam int SPC_W      = 6;
    localparam int SPC_SHIFT  = 5;
    localparam int CODE_W     = 5;
    localparam int KIND_W     = 4;
    localparam int BASE_ALIGN = 10;
    localparam int VEC_IDX_W  = $clog2(IRQ_W);

    typedef logic [VA_W-1:0] word_t;

    // Status word field positions
    localparam int ST_EXL   = 1;
    localparam int ST_UX    = 5;
    localparam int ST_SX    = 6;
    localparam int ST_KX    = 7;
    localparam int ST_IM_LO = 8;
    localparam int ST_BEV   = 22;

    // Cause word field positions
    localparam int CA_CODE_LO = 2;
    localparam int CA_IP_LO   = 8;
    localparam int CA_IV      = 23;
    localparam int CA_BD      = 31;

    // Config3 word field positions
    localparam int C3_VINT    = 5;
    localparam int C3_VEIC    = 6;
    localparam int C3_ISA_EXC = 16;

    localparam word_t BOOT_VEC     = 32'hBFC0_0000;
    localparam word_t DEBUG_VEC    = 32'hBFC0_0480;
    localparam word_t BEV_BASE     = 32'hBFC0_0200;
    localparam word_t OFS_GENERAL  = 32'h0000_0180;
    localparam word_t OFS_IRQ_AREA = 32'h0000_0200;
    localparam word_t OFS_REFILL_X = 32'h0000_0080;
    localparam word_t OFS_REFILL   = 32'h0000_0000;

    localparam logic [CODE_W-1:0] CODE_IRQ    = 5'd0;
    localparam logic [CODE_W-1:0] CODE_THREAD = 5'd25;
    localparam logic [CODE_W-1:0] CODE_DSP    = 5'd26;
    localparam logic [CODE_W-1:0] CODE_CACHE  = 5'd30;

    typedef enum logic [KIND_W-1:0] {
        EK_RESET      = 4'd0,
        EK_SOFT_RESET = 4'd1,
        EK_NMI        = 4'd2,
        EK_DEBUG      = 4'd3,
        EK_IRQ        = 4'd4,
        EK_REFILL     = 4'd5,
        EK_OTHER      = 4'd6,
        EK_THREAD     = 4'd7,
        EK_DSP_OFF    = 4'd8,
        EK_CACHE_ERR  = 4'd9
    } exc_kind_e;

    typedef enum logic [1:0] {
        PC_BOOT,
        PC_DEBUG,
        PC_BASED
    } pc_src_e;

    typedef struct packed {
        pc_src_e           src;
        word_t             offset;
        logic              set_code;
        logic [CODE_W-1:0] code;
        logic              clr_bd;
    } entry_plan_t;

    // Map a raw kind code onto the enum; unassigned codes act as "other".
    function automatic exc_kind_e decode_kind(input logic [KIND_W-1:0] raw);
        exc_kind_e k;
        case (raw)
            4'd0:    k = EK_RESET;
            4'd1:    k = EK_SOFT_RESET;
            4'd2:    k = EK_NMI;
            4'd3:    k = EK_DEBUG;
            4'd4:    k = EK_IRQ;
            4'd5:    k = EK_REFILL;
            4'd7:    k = EK_THREAD;
            4'd8:    k = EK_DSP_OFF;
            4'd9:    k = EK_CACHE_ERR;
            default: k = EK_OTHER;
        endcase
        return k;
    endfunction

    // Highest set bit among positions IRQ_W-1 .. 1; zero when none is set.
    function automatic logic [VEC_IDX_W-1:0] top_pending(input logic [IRQ_W-1:0] p);
        logic [VEC_IDX_W-1:0] v;
        v = '0;
        for (int i = 1; i < IRQ_W; i++) begin
            if (p[i]) v = VEC_IDX_W'(i);
        end
        return v;
    endfunction

endpackage

// File: rtl/exc_irq_vector.sv
module exc_irq_vector
    import exc_vec_pkg::*;
(
    input  logic [IRQ_W-1:0]     pend_raw,
    input  logic [IRQ_W-1:0]     irq_mask,
    input  logic                 iv_bit,
    input  logic                 int_vec_en,
    input  logic                 ext_vec_en,
    input  logic [SPC_RAW_W-1:0] spacing_raw,
    output word_t                irq_offset
);

    logic [IRQ_W-1:0]    pend_masked;
    word_t               spacing;
    logic [IRQ_W-1:0]    vector;
    logic                unused_spc;

    assign pend_masked = pend_raw & irq_mask;
    assign spacing     = word_t'(spacing_raw[SPC_W-1:0]) << SPC_SHIFT;
    assign unused_spc  = ^spacing_raw[SPC_RAW_W-1:SPC_W];

    // Internal scan has precedence over the external controller's value.
    always_comb begin
        if (int_vec_en) begin
            vector = IRQ_W'(top_pending(pend_masked));
        end else begin
            vector = pend_masked;
        end
    end

    always_comb begin
        if (int_vec_en || ext_vec_en) begin
            irq_offset = OFS_IRQ_AREA + (word_t'(vector) * spacing);
        end else if (iv_bit) begin
            irq_offset = OFS_IRQ_AREA;
        end else begin
            irq_offset = OFS_GENERAL;
        end
    end

endmodule

// File: rtl/exc_entry_plan.sv
module exc_entry_plan
    import exc_vec_pkg::*;
(
    input  exc_kind_e         kind,
    input  logic [1:0]        region,
    input  logic [CODE_W-1:0] code_in,
    input  logic              ux_en,
    input  logic              sx_en,
    input  logic              kx_en,
    input  word_t             irq_offset,
    output entry_plan_t       plan
);

    logic refill_ext;

    always_comb begin
        case (region)
            2'd0:    refill_ext = ux_en;
            2'd1:    refill_ext = sx_en;
            2'd3:    refill_ext = kx_en;
            default: refill_ext = 1'b0;
        endcase
    end

    always_comb begin
        plan.src      = PC_BASED;
        plan.offset   = OFS_GENERAL;
        plan.set_code = 1'b1;
        plan.code     = code_in;
        plan.clr_bd   = 1'b0;
        case (kind)
            EK_RESET, EK_SOFT_RESET: begin
                plan.src      = PC_BOOT;
                plan.set_code = 1'b0;
            end
            EK_NMI: begin
                plan.src      = PC_BOOT;
                plan.set_code = 1'b0;
                plan.clr_bd   = 1'b1;
            end
            EK_DEBUG: begin
                plan.src      = PC_DEBUG;
                plan.set_code = 1'b0;
                plan.clr_bd   = 1'b1;
            end
            EK_IRQ: begin
                plan.offset = irq_offset;
                plan.code   = CODE_IRQ;
            end
            EK_REFILL: begin
                plan.offset = refill_ext ? OFS_REFILL_X : OFS_REFILL;
            end
            EK_THREAD:    plan.code = CODE_THREAD;
            EK_DSP_OFF:   plan.code = CODE_DSP;
            EK_CACHE_ERR: plan.code = CODE_CACHE;
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_cause_update.sv
module exc_cause_update
    import exc_vec_pkg::*;
(
    input  word_t       cause_cur,
    input  entry_plan_t plan,
    input  logic        exl,
    output word_t       cause_next
);

    always_comb begin
        cause_next = cause_cur;
        if (plan.set_code) begin
            cause_next[CA_CODE_LO +: CODE_W] = plan.code;
        end
        if (plan.clr_bd && !exl) begin
            cause_next[CA_BD] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_vec_pkg::*;
#(
    parameter bit HAS_CISA = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  exc_kind,
    input  logic [1:0]  fault_region,
    input  logic [4:0]  exc_code,
    input  logic [31:0] status_in,
    input  logic [31:0] cause_in,
    input  logic [31:0] config3_in,
    input  logic [7:0]  intctl_spacing,
    input  logic [31:0] ebase_in,
    output logic        out_valid,
    output logic [31:0] new_pc,
    output logic [31:0] cause_out,
    output logic        isa16_mode
);

    exc_kind_e   kind;
    word_t       irq_offset;
    entry_plan_t plan;
    word_t       base;
    word_t       pc_next;
    word_t       cause_next;
    logic        isa_next;
    logic        unused_fields;

    assign kind          = decode_kind(exc_kind);
    assign unused_fields = ^{status_in, config3_in, ebase_in[BASE_ALIGN-1:0]};

    exc_irq_vector u_irq (
        .pend_raw    (cause_in[CA_IP_LO +: IRQ_W]),
        .irq_mask    (status_in[ST_IM_LO +: IRQ_W]),
        .iv_bit      (cause_in[CA_IV]),
        .int_vec_en  (config3_in[C3_VINT]),
        .ext_vec_en  (config3_in[C3_VEIC]),
        .spacing_raw (intctl_spacing),
        .irq_offset  (irq_offset)
    );

    exc_entry_plan u_plan (
        .kind       (kind),
        .region     (fault_region),
        .code_in    (exc_code),
        .ux_en      (status_in[ST_UX]),
        .sx_en      (status_in[ST_SX]),
        .kx_en      (status_in[ST_KX]),
        .irq_offset (irq_offset),
        .plan       (plan)
    );

    exc_cause_update u_cause (
        .cause_cur  (cause_in),
        .plan       (plan),
        .exl        (status_in[ST_EXL]),
        .cause_next (cause_next)
    );

    assign base = status_in[ST_BEV] ? BEV_BASE
                                    : {ebase_in[VA_W-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};

    always_comb begin
        case (plan.src)
            PC_BOOT:  pc_next = BOOT_VEC;
            PC_DEBUG: pc_next = DEBUG_VEC;
            default:  pc_next = base + plan.offset;
        endcase
    end

    generate
        if (HAS_CISA) begin : g_cisa
            assign isa_next = config3_in[C3_ISA_EXC];
        end else begin : g_no_cisa
            assign isa_next = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            new_pc     <= '0;
            cause_out  <= '0;
            isa16_mode <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                new_pc     <= pc_next;
                cause_out  <= cause_next;
                isa16_mode <= isa_next;
            end
        end
    end

endmodule

// File: rtl/exc_vector_gen_chk.sv
module exc_vector_gen_chk #(
    parameter bit HAS_CISA = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [3:0]  exc_kind,
    input logic [31:0] status_in,
    input logic [31:0] cause_in,
    input logic [31:0] config3_in,
    input logic        out_valid,
    input logic [31:0] new_pc,
    input logic [31:0] cause_out,
    input logic        isa16_mode
);

    localparam logic [31:0] KEEP_MASK = 32'h7FFF_FF83;

    assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && $stable(new_pc) && $stable(cause_out) && $stable(isa16_mode)));

    assert_clear_R2: assert property (@(posedge clk)
        rst |=> (!out_valid && new_pc == 32'h0 && cause_out == 32'h0 && !isa16_mode));

    assert_boot_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && exc_kind <= 4'd2) |=> (new_pc == 32'hBFC0_0000));

    assert_debug_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && exc_kind == 4'd3) |=> (new_pc == 32'hBFC0_0480));

    assert_bd_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (exc_kind != 4'd2 && exc_kind != 4'd3 || status_in[1]))
        |=> (cause_out[31] == $past(cause_in[31])));

    assert_general_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && exc_kind == 4'd6 && !status_in[22]) |=> (new_pc[9:0] == 10'h180));

    assert_keep_bits_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ((cause_out & KEEP_MASK) == ($past(cause_in) & KEEP_MASK)));

    assert_irq_code_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && exc_kind == 4'd4) |=> (cause_out[6:2] == 5'd0));

    assert_isa_flag_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (isa16_mode == (HAS_CISA ? $past(config3_in[16]) : 1'b0)));

endmodule

bind exc_vector_gen exc_vector_gen_chk #(.HAS_CISA(HAS_CISA)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .exc_kind   (exc_kind),
    .status_in  (status_in),
    .cause_in   (cause_in),
    .config3_in (config3_in),
    .out_valid  (out_valid),
    .new_pc     (new_pc),
    .cause_out  (cause_out),
    .isa16_mode (isa16_mode)
);

// File: tb/exc_vector_gen_bench.sv
module exc_vector_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [3:0]  kind;
        logic [1:0]  region;
        logic [4:0]  code;
        logic [31:0] status;
        logic [31:0] cause;
        logic [31:0] cfg3;
        logic [7:0]  vs;
        logic [31:0] ebase;
        logic [31:0] exp_pc;
        logic [31:0] exp_cause;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        // R5: plain interrupt, default offset, code bits cleared
        '{4'd4, 2'd0, 5'd0, 32'h0000FF00, 32'h0000007C, 32'h0, 8'h00, 32'h80001234, 32'h80001180, 32'h00000000, 4'd5},
        // R7: IV set
        '{4'd4, 2'd0, 5'd0, 32'h0000FF00, 32'h00800400, 32'h0, 8'h00, 32'h80001234, 32'h80001200, 32'h00800400, 4'd7},
        // R9: internal scan picks line 5, spacing 32
        '{4'd4, 2'd0, 5'd0, 32'h0000FF00, 32'h00002400, 32'h20, 8'h01, 32'h80001234, 32'h800012A0, 32'h00002400, 4'd9},
        // R8: mask leaves line 2, spacing bits 7:6 ignored
        '{4'd4, 2'd0, 5'd0, 32'h00000F00, 32'h0000F400, 32'h20, 8'hC2, 32'h80001234, 32'h80001280, 32'h0000F400, 4'd8},
        // R9: only line 0 pending gives vector 0
        '{4'd4, 2'd0, 5'd0, 32'h0000FF00, 32'h00000100, 32'h20, 8'h01, 32'h80001234, 32'h80001200, 32'h00000100, 4'd9},
        // R10: external vector 0x2B, spacing 128
        '{4'd4, 2'd0, 5'd0, 32'h0000FF00, 32'h00002B00, 32'h40, 8'h04, 32'h80001234, 32'h80002780, 32'h00002B00, 4'd10},
        // R9: both modes on, internal wins
        '{4'd4, 2'd0, 5'd0, 32'h0000FF00, 32'h00002B00, 32'h60, 8'h04, 32'h80001234, 32'h80001480, 32'h00002B00, 4'd9},
        // R5: BEV base
        '{4'd4, 2'd0, 5'd0, 32'h00400000, 32'h00000000, 32'h0, 8'h00, 32'h80001234, 32'hBFC00380, 32'h00000000, 4'd5},
        // R3: reset keeps Cause
        '{4'd0, 2'd0, 5'd7, 32'h00000000, 32'h8000007C, 32'h60, 8'h11, 32'h12345678, 32'hBFC00000, 32'h8000007C, 4'd3},
        // R4: NMI, EXL clear, BD cleared
        '{4'd2, 2'd0, 5'd0, 32'h00000000, 32'h80000010, 32'h0, 8'h00, 32'h80001234, 32'hBFC00000, 32'h00000010, 4'd4},
        // R4: NMI, EXL set, BD kept
        '{4'd2, 2'd0, 5'd0, 32'h00000002, 32'h80000010, 32'h0, 8'h00, 32'h80001234, 32'hBFC00000, 32'h80000010, 4'd4},
        // R3 and R12: debug entry, ISA flag set
        '{4'd3, 2'd0, 5'd0, 32'h00000000, 32'h80000000, 32'h00010000, 8'h00, 32'h80001234, 32'hBFC00480, 32'h00000000, 4'd3},
        // R3: soft reset keeps BD
        '{4'd1, 2'd0, 5'd0, 32'h00000000, 32'h80000000, 32'h0, 8'h00, 32'h80001234, 32'hBFC00000, 32'h80000000, 4'd3},
        // R11: user region, UX set
        '{4'd5, 2'd0, 5'd2, 32'h00000020, 32'h00000000, 32'h0, 8'h00, 32'h80001234, 32'h80001080, 32'h00000008, 4'd11},
        // R11: supervisor region, SX clear
        '{4'd5, 2'd1, 5'd3, 32'h00000020, 32'h00000000, 32'h0, 8'h00, 32'h80001234, 32'h80001000, 32'h0000000C, 4'd11},
        // R11: kernel region, KX set
        '{4'd5, 2'd3, 5'd2, 32'h00000080, 32'h00000000, 32'h0, 8'h00, 32'h80001234, 32'h80001080, 32'h00000008, 4'd11},
        // R11: region 2 never extended
        '{4'd5, 2'd2, 5'd2, 32'h000000E0, 32'h00000000, 32'h0, 8'h00, 32'h80001234, 32'h80001000, 32'h00000008, 4'd11},
        // R6: thread code 25, other bits preserved
        '{4'd7, 2'd0, 5'd0, 32'h00000000, 32'h80FF0003, 32'h0, 8'h00, 32'h80001234, 32'h80001180, 32'h80FF0067, 4'd6},
        // R6: DSP disabled code 26
        '{4'd8, 2'd0, 5'd0, 32'h00000000, 32'h00000000, 32'h0, 8'h00, 32'h80001234, 32'h80001180, 32'h00000068, 4'd6},
        // R6: cache error code 30 under BEV
        '{4'd9, 2'd0, 5'd0, 32'h00400000, 32'h00000000, 32'h0, 8'h00, 32'h80001234, 32'hBFC00380, 32'h00000078, 4'd6},
        // R5: base alignment, code from input
        '{4'd6, 2'd0, 5'd12, 32'h00000000, 32'h00000000, 32'h0, 8'h00, 32'hFFFFFFFF, 32'hFFFFFD80, 32'h00000030, 4'd5},
        // R10: largest vector and spacing, address wraps
        '{4'd4, 2'd0, 5'd0, 32'h0000FF00, 32'h0000FF00, 32'h40, 8'h3F, 32'hFFFFFC00, 32'h0007D620, 32'h0000FF00, 4'd10},
        // R13: unassigned kind 12 acts as other
        '{4'd12, 2'd0, 5'd9, 32'h00000000, 32'h00000000, 32'h0, 8'h00, 32'h80001234, 32'h80001180, 32'h00000024, 4'd13},
        // R10: vectored with nothing pending overrides IV, ISA flag set
        '{4'd4, 2'd0, 5'd0, 32'h00000000, 32'h00800F00, 32'h00010040, 8'h04, 32'h80001234, 32'h80001200, 32'h00800F00, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  exc_kind = '0;
    logic [1:0]  fault_region = '0;
    logic [4:0]  exc_code = '0;
    logic [31:0] status_in = '0;
    logic [31:0] cause_in = '0;
    logic [31:0] config3_in = '0;
    logic [7:0]  intctl_spacing = '0;
    logic [31:0] ebase_in = '0;
    logic        out_valid;
    logic [31:0] new_pc;
    logic [31:0] cause_out;
    logic        isa16_mode;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_gen u_exc_vector_gen (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .exc_kind       (exc_kind),
        .fault_region   (fault_region),
        .exc_code       (exc_code),
        .status_in      (status_in),
        .cause_in       (cause_in),
        .config3_in     (config3_in),
        .intctl_spacing (intctl_spacing),
        .ebase_in       (ebase_in),
        .out_valid      (out_valid),
        .new_pc         (new_pc),
        .cause_out      (cause_out),
        .isa16_mode     (isa16_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        exc_kind       = v.kind;
        fault_region   = v.region;
        exc_code       = v.code;
        status_in      = v.status;
        cause_in       = v.cause;
        config3_in     = v.cfg3;
        intctl_spacing = v.vs;
        ebase_in       = v.ebase;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] held_pc;
        logic [31:0] held_cause;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 out_valid", 32'(out_valid), 32'h0);
        check("R2 new_pc", new_pc, 32'h0);
        check("R2 cause_out", cause_out, 32'h0);
        check("R2 isa16_mode", 32'(isa16_mode), 32'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R%0d vec %0d new_pc", TBL[i].req, i), new_pc, TBL[i].exp_pc);
            check($sformatf("R%0d vec %0d cause_out", TBL[i].req, i), cause_out, TBL[i].exp_cause);
            check($sformatf("R12 vec %0d isa16_mode", i), 32'(isa16_mode), 32'(TBL[i].cfg3[16]));
            check($sformatf("R1 vec %0d out_valid", i), 32'(out_valid), 32'h1);
        end

        // R1: idle cycles hold results while inputs change
        held_pc    = new_pc;
        held_cause = cause_out;
        apply(TBL[5]);
        @(negedge clk);
        check("R1 strobe drops", 32'(out_valid), 32'h0);
        check("R1 pc held", new_pc, held_pc);
        apply(TBL[17]);
        @(negedge clk);
        check("R1 cause held", cause_out, held_cause);
        check("R1 still idle", 32'(out_valid), 32'h0);

        // R1: back-to-back requests
        apply(TBL[1]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R1 b2b first pc", new_pc, TBL[1].exp_pc);
        check("R1 b2b first valid", 32'(out_valid), 32'h1);
        apply(TBL[11]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 b2b second pc", new_pc, TBL[11].exp_pc);
        check("R1 b2b second valid", 32'(out_valid), 32'h1);
        @(negedge clk);
        check("R1 b2b ends", 32'(out_valid), 32'h0);

        // R2: reset during operation clears outputs, even with a request
        apply(TBL[2]);
        req_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R2 mid pc", new_pc, 32'h0);
        check("R2 mid valid", 32'(out_valid), 32'h0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule